// File: doc/BRIEF.md
# HDLC Bit-Stuffing Frame Transmitter

This block turns byte frames into a serial HDLC bit stream and sends one bit on each clock where the bit enable is high. Bytes enter through a push interface. Each byte carries two tags: one marks the last byte of a frame and the other asks for an abort. The bytes wait in a small queue. The transmitter wraps each frame in flag bytes and appends a 16-bit frame check sequence. Inside the frame body it inserts a zero after every run of five ones, so the receiver never sees a flag or an abort pattern in the data.

A two-bit mode input selects what goes on the line when no frame is being sent: steady ones, back-to-back flags, or repeated Go Ahead patterns. The Go Ahead mode holds the line even when data is waiting, until the mode is changed. An end-of-packet output marks the last bit of each frame on the line. An underrun output marks a frame that was cut short because the queue ran dry.

Top module: `hdlcFrameTx`

## Requirements
- R1: While reset is held and just after it is released, txBit is 1, eop and underrun are 0, and pushReady is 1.
- R2: A frame goes out in this order: the flag 01111110, the data bytes (each sent least significant bit first), two FCS bytes, then a closing flag.
- R3: The FCS is a CRC with generator x^16+x^12+x^5+1. It is processed in reflected form, starts from all ones, and covers every data bit. The complement of the remainder is sent low byte first and least significant bit first, so the nine ASCII bytes "123456789" give the 16-bit value 0x906E.
- R4: Inside the data and FCS bits, a 0 is sent after every five consecutive 1s. A run of ones that crosses a byte boundary or reaches the final FCS bit counts as one run. Flags and aborts are never stuffed.
- R5: A queued entry with the abort tag set sends eight 1s (unstuffed) in place of a byte. That ends the frame, and the line returns to the fill pattern.
- R6: If the queue is empty when the next body byte is due and no last-tagged byte has been sent, the frame is aborted with eight 1s. underrun is high for exactly the bit period of the first abort bit.
- R7: fillMode 00 gives continuous 1s. Queued data ends this fill at the next 8-bit fill boundary.
- R8: fillMode 01 and fillMode 11 send the flag 01111110 back to back. Queued data ends this fill at the next flag boundary.
- R9: fillMode 10 sends 011111110 over and over, even while data is queued. The queued frame starts only after the mode changes.
- R10: eop is high for exactly one bit period, during the last bit of a closing flag or of an abort.
- R11: txBit and eop change only on clock edges where bitEn is high. Otherwise they hold their values.
- R12: If the next frame is already queued when a closing flag ends, that frame's opening flag follows at once, with no fill in between.
- R13: The queue holds DEPTH entries (default 4). pushReady is 0 while the queue is full, and a push made while pushReady is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Bit enable: one line bit per enabled clock |
| fillMode | input | 2 | 00 ones, 01/11 flags, 10 Go Ahead |
| pushValid | input | 1 | Push strobe for a queue entry |
| pushData | input | 8 | Data byte |
| pushLast | input | 1 | Byte is the last of its frame |
| pushAbort | input | 1 | Entry requests an abort instead of a byte |
| pushReady | output | 1 | Queue can accept an entry |
| txBit | output | 1 | Serial line output |
| eop | output | 1 | End-of-packet marker, one bit period |
| underrun | output | 1 | Frame cut short by an empty queue, one bit period |

## Verification
The bench drives several byte patterns and compares the line bit for bit with a stream it builds itself:
- A sparse pattern checks the framing and the CRC with almost no stuffing.
- A pattern heavy in ones places runs of ones across byte boundaries and into the FCS.
- The string "123456789" is destuffed from the line to confirm the known check value.

It also covers:
- an abort tag and a queue that runs dry mid-frame, which produce the same line bits and differ only on the underrun output;
- two frames queued back to back;
- each fill mode, including a full queue held behind Go Ahead, where an extra dropped push must never appear on the line;
- a run with the bit enable high only every third clock, which shows the stream does not depend on clock rate.

// File: rtl/hdlcTxPkg.sv
package hdlcTxPkg;

  localparam int BYTE_W     = 8;
  localparam int STUFF_RUN  = 5;
  localparam int SYM_MAX_W  = 9;
  localparam int SYM_LEN_W  = 4;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [SYM_MAX_W-1:0] FLAG_SYM  = 9'h07E;
  localparam logic [SYM_MAX_W-1:0] ONES_SYM  = 9'h0FF;
  localparam logic [SYM_MAX_W-1:0] GA_SYM    = 9'h0FE;

  typedef enum logic [1:0] {
    FILL_ONES  = 2'b00,
    FILL_FLAGS = 2'b01,
    FILL_GA    = 2'b10,
    FILL_ALT   = 2'b11
  } fillMode_t;

  typedef enum logic [2:0] {
    SEL_ONES,
    SEL_FLAG,
    SEL_CLOSE,
    SEL_ABORT,
    SEL_GA,
    SEL_DATA,
    SEL_FCS_LO,
    SEL_FCS_HI
  } symSel_t;

  typedef struct packed {
    logic    load;
    symSel_t sel;
    logic    crcInit;
  } txStrobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] crc, input logic b);
    logic [15:0] nxt;
    nxt = crc >> 1;
    if (crc[0] ^ b) nxt = nxt ^ CRC_POLY_REFL;
    return nxt;
  endfunction

endpackage

// File: rtl/hdlcTxQueue.sv
module hdlcTxQueue #(
  parameter int ENTRY_W = 10,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ENTRY_W-1:0] wrEntry,
  input  logic               rdEn,
  output logic [ENTRY_W-1:0] headEntry,
  output logic               empty,
  output logic               ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               doWr, doRd;

  assign empty     = (count == '0);
  assign ready     = (count != FULL_CNT);
  assign doWr      = wrEn && ready;
  assign doRd      = rdEn && !empty;
  assign headEntry = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) store[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      if (doWr && !doRd)      count <= count + 1'b1;
      else if (doRd && !doWr) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/hdlcTxCtrl.sv
module hdlcTxCtrl
  import hdlcTxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      symDone,
  input  logic [1:0] fillMode,
  input  logic      qEmpty,
  input  logic      headLast,
  input  logic      headAbort,
  output txStrobe_t strb,
  output logic      pop,
  output logic      underrun
);
  typedef enum logic [1:0] {ST_FILL, ST_BODY, ST_FCS_LO, ST_FCS_HI} ctrlState_t;

  ctrlState_t state, nState;
  logic       lastSent, nLastSent;
  logic       popWant, dryWant;

  always_comb begin
    strb.load    = bitEn && symDone;
    strb.sel     = SEL_ONES;
    strb.crcInit = 1'b0;
    nState       = state;
    nLastSent    = lastSent;
    popWant      = 1'b0;
    dryWant      = 1'b0;
    unique case (state)
      ST_FILL: begin
        if (fillMode != FILL_GA && !qEmpty) begin
          strb.sel     = SEL_FLAG;
          strb.crcInit = 1'b1;
          nState       = ST_BODY;
          nLastSent    = 1'b0;
        end else begin
          unique case (fillMode)
            FILL_ONES: strb.sel = SEL_ONES;
            FILL_GA:   strb.sel = SEL_GA;
            default:   strb.sel = SEL_FLAG;
          endcase
        end
      end
      ST_BODY: begin
        if (lastSent) begin
          strb.sel = SEL_FCS_LO;
          nState   = ST_FCS_LO;
        end else if (qEmpty) begin
          strb.sel = SEL_ABORT;
          dryWant  = 1'b1;
          nState   = ST_FILL;
        end else if (headAbort) begin
          strb.sel = SEL_ABORT;
          popWant  = 1'b1;
          nState   = ST_FILL;
        end else begin
          strb.sel  = SEL_DATA;
          popWant   = 1'b1;
          nLastSent = headLast;
        end
      end
      ST_FCS_LO: begin
        strb.sel = SEL_FCS_HI;
        nState   = ST_FCS_HI;
      end
      default: begin
        strb.sel = SEL_CLOSE;
        nState   = ST_FILL;
      end
    endcase
  end

  assign pop = strb.load && popWant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_FILL;
      lastSent <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (strb.load) begin
        state    <= nState;
        lastSent <= nLastSent;
      end
      if (bitEn) underrun <= strb.load && dryWant;
    end
  end
endmodule

// File: rtl/hdlcTxDatapath.sv
module hdlcTxDatapath
  import hdlcTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  txStrobe_t         strb,
  input  logic [BYTE_W-1:0] headData,
  output logic              symDone,
  output logic              txBit,
  output logic              eop
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [ONES_W-1:0] RUN_LIMIT = ONES_W'(STUFF_RUN);

  logic [SYM_MAX_W-1:0] shiftReg, symVal;
  logic [SYM_LEN_W-1:0] bitsLeft, symLen;
  logic [ONES_W-1:0]    onesCnt, onesBase;
  logic [15:0]          crc;
  symSel_t              curSel;
  logic                 stuffOn, stuffSel, stuffDue, endSym;

  always_comb begin
    symLen = SYM_LEN_W'(BYTE_W);
    unique case (strb.sel)
      SEL_FLAG, SEL_CLOSE: symVal = FLAG_SYM;
      SEL_GA: begin
        symVal = GA_SYM;
        symLen = SYM_LEN_W'(SYM_MAX_W);
      end
      SEL_DATA:   symVal = {1'b0, headData};
      SEL_FCS_LO: symVal = {1'b0, ~crc[7:0]};
      SEL_FCS_HI: symVal = {1'b0, ~crc[15:8]};
      default:    symVal = ONES_SYM;
    endcase
  end

  assign stuffSel = (strb.sel == SEL_DATA) || (strb.sel == SEL_FCS_LO) ||
                    (strb.sel == SEL_FCS_HI);
  assign stuffDue = stuffOn && (onesCnt == RUN_LIMIT);
  assign symDone  = (bitsLeft == '0) && !stuffDue;
  assign onesBase = stuffOn ? onesCnt : '0;
  assign endSym   = (curSel == SEL_CLOSE) || (curSel == SEL_ABORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      onesCnt  <= '0;
      stuffOn  <= 1'b0;
      curSel   <= SEL_ONES;
      crc      <= CRC_PRESET;
      txBit    <= 1'b1;
      eop      <= 1'b0;
    end else if (bitEn) begin
      if (strb.load) begin
        txBit    <= symVal[0];
        shiftReg <= symVal >> 1;
        bitsLeft <= symLen - 1'b1;
        stuffOn  <= stuffSel;
        curSel   <= strb.sel;
        eop      <= 1'b0;
        if (stuffSel) onesCnt <= symVal[0] ? onesBase + 1'b1 : '0;
        else          onesCnt <= '0;
        if (strb.crcInit)              crc <= CRC_PRESET;
        else if (strb.sel == SEL_DATA) crc <= crcStep(crc, symVal[0]);
      end else if (stuffDue) begin
        txBit   <= 1'b0;
        onesCnt <= '0;
        eop     <= 1'b0;
      end else if (bitsLeft != '0) begin
        txBit    <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
        eop      <= (bitsLeft == SYM_LEN_W'(1)) && endSym;
        if (stuffOn) onesCnt <= shiftReg[0] ? onesCnt + 1'b1 : '0;
        if (curSel == SEL_DATA) crc <= crcStep(crc, shiftReg[0]);
      end
    end
  end
endmodule

// File: rtl/hdlcFrameTx.sv
module hdlcFrameTx
  import hdlcTxPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic [1:0]  fillMode,
  input  logic        pushValid,
  input  logic [7:0]  pushData,
  input  logic        pushLast,
  input  logic        pushAbort,
  output logic        pushReady,
  output logic        txBit,
  output logic        eop,
  output logic        underrun
);
  localparam int ENTRY_W = BYTE_W + 2;

  logic [ENTRY_W-1:0] headEntry;
  logic               qEmpty, pop, symDone;
  txStrobe_t          strb;

  hdlcTxQueue #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) queue_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (pushValid),
    .wrEntry   ({pushAbort, pushLast, pushData}),
    .rdEn      (pop),
    .headEntry (headEntry),
    .empty     (qEmpty),
    .ready     (pushReady)
  );

  hdlcTxCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .symDone   (symDone),
    .fillMode  (fillMode),
    .qEmpty    (qEmpty),
    .headLast  (headEntry[BYTE_W]),
    .headAbort (headEntry[BYTE_W+1]),
    .strb      (strb),
    .pop       (pop),
    .underrun  (underrun)
  );

  hdlcTxDatapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .strb     (strb),
    .headData (headEntry[BYTE_W-1:0]),
    .symDone  (symDone),
    .txBit    (txBit),
    .eop      (eop)
  );
endmodule

// File: rtl/hdlcFrameTxChk.sv
module hdlcFrameTxChk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic txBit,
  input logic eop,
  input logic underrun
);
  // R10: end marker never spans two bit periods
  a_r10_eop_single: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && eop) |=> !eop);

  // R11: line output frozen on clocks without bit enable
  a_r11_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R6: underrun marker lasts one bit period
  a_r6_underrun_single: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && underrun) |=> !underrun);

  // R6: underrun marker coincides with the first abort one
  a_r6_underrun_starts_abort: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> txBit);
endmodule

bind hdlcFrameTx hdlcFrameTxChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .bitEn    (bitEn),
  .txBit    (txBit),
  .eop      (eop),
  .underrun (underrun)
);

// File: tb/hdlcFrameTx_tb.sv
module hdlcFrameTx_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [1:0] fillMode = 2'b00;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic       pushLast = 1'b0;
  logic       pushAbort = 1'b0;
  logic       pushReady, txBit, eop, underrun;

  int testsRun = 0;
  int testsFailed = 0;
  int enPeriod = 1;
  int phase = 0;
  int holdErr = 0;
  logic enHit = 1'b0;
  logic lastTx = 1'b1;

  bit cap[$];
  bit eopCap[$];
  bit ufCap[$];
  bit expQ[$];
  bit patQ[$];
  logic [7:0] frameBytes[$];
  int expOnes;

  hdlcFrameTx dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .fillMode(fillMode),
    .pushValid(pushValid), .pushData(pushData), .pushLast(pushLast),
    .pushAbort(pushAbort), .pushReady(pushReady), .txBit(txBit),
    .eop(eop), .underrun(underrun)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    phase = phase + 1;
    bitEn = ((phase % enPeriod) == 0);
  end

  always @(posedge clk) enHit <= bitEn && rstN;

  always @(negedge clk) begin
    if (enHit) begin
      cap.push_back(txBit);
      eopCap.push_back(eop);
      ufCap.push_back(underrun);
    end else if (rstN && txBit !== lastTx) begin
      holdErr = holdErr + 1;
    end
    lastTx = txBit;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearCap();
    cap.delete(); eopCap.delete(); ufCap.delete();
  endtask

  task automatic waitBits(input int n);
    repeat (n * enPeriod) @(negedge clk);
  endtask

  task automatic pushEntry(input logic [7:0] d, input bit last, input bit abt);
    @(negedge clk);
    while (!pushReady) @(negedge clk);
    pushValid = 1'b1; pushData = d; pushLast = last; pushAbort = abt;
    @(negedge clk);
    pushValid = 1'b0; pushLast = 1'b0; pushAbort = 1'b0;
  endtask

  task automatic pushFrame();
    foreach (frameBytes[i]) pushEntry(frameBytes[i], i == frameBytes.size() - 1, 1'b0);
  endtask

  task automatic addRaw(input logic [7:0] v);
    for (int i = 0; i < 8; i++) expQ.push_back(v[i]);
    expOnes = 0;
  endtask

  task automatic addStuffed(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      expQ.push_back(v[i]);
      if (v[i]) begin
        expOnes++;
        if (expOnes == 5) begin expQ.push_back(1'b0); expOnes = 0; end
      end else expOnes = 0;
    end
  endtask

  function automatic logic [15:0] refFcs();
    logic [15:0] c = 16'hFFFF;
    foreach (frameBytes[k])
      for (int i = 0; i < 8; i++)
        c = (c >> 1) ^ ((c[0] ^ frameBytes[k][i]) ? 16'h8408 : 16'h0000);
    return ~c;
  endfunction

  task automatic addFrame(input bit withFcs);
    logic [15:0] f;
    addRaw(8'h7E);
    foreach (frameBytes[k]) addStuffed(frameBytes[k]);
    if (withFcs) begin
      f = refFcs();
      addStuffed(f[7:0]); addStuffed(f[15:8]);
      addRaw(8'h7E);
    end
  endtask

  function automatic int firstZero();
    foreach (cap[i]) if (cap[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int mismatchAt(input int s);
    if (s < 0 || s + expQ.size() > cap.size()) return 9999;
    for (int i = 0; i < expQ.size(); i++) if (cap[s+i] != expQ[i]) return i;
    return -1;
  endfunction

  function automatic int findSeq();
    for (int s = 0; s + expQ.size() <= cap.size(); s++)
      if (mismatchAt(s) == -1) return s;
    return -1;
  endfunction

  function automatic bit periodic();
    for (int k = 0; k < patQ.size(); k++) begin
      bit good = 1'b1;
      foreach (cap[i]) if (cap[i] != patQ[(i + k) % patQ.size()]) good = 1'b0;
      if (good && cap.size() > 2 * patQ.size()) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int countOnes(input bit q[$]);
    int n = 0;
    foreach (q[i]) n += q[i];
    return n;
  endfunction

  task automatic setPat(input logic [8:0] v, input int n);
    patQ.delete();
    for (int i = 0; i < n; i++) patQ.push_back(v[i]);
  endtask

  task automatic goIdle();
    fillMode = 2'b00;
    waitBits(30);
    clearCap(); expQ.delete();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(txBit == 1'b1, "R1", "txBit in reset", txBit, 1);
    check(eop == 1'b0 && underrun == 1'b0, "R1", "eop/underrun in reset", {eop, underrun}, 0);
    check(pushReady == 1'b1, "R1", "pushReady in reset", pushReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(txBit == 1'b1 && eop == 1'b0, "R1", "line after release", {txBit, eop}, 2);
  endtask

  task automatic runIdleFrame(input string req);
    int z, mm;
    goIdle();
    pushFrame();
    addFrame(1'b1);
    waitBits(expQ.size() + 60);
    z = firstZero();
    mm = mismatchAt(z);
    check(mm == -1, req, "frame bits first mismatch index", mm, -1);
    check(z >= 0 && eopCap[z + expQ.size() - 1] == 1'b1 && countOnes(eopCap) == 1,
          "R10", "eop on closing flag last bit, count", countOnes(eopCap), 1);
  endtask

  task automatic testPlainFrame();
    frameBytes = '{8'h12, 8'h34, 8'h56};
    runIdleFrame("R2 R3 R7");
  endtask

  task automatic testStuffFrame();
    frameBytes = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8};
    runIdleFrame("R4");
  endtask

  task automatic testCheckVector();
    int z, idx, ones;
    bit d[$];
    logic [15:0] got;
    frameBytes = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    runIdleFrame("R3 R4");
    z = firstZero();
    idx = z + 8; ones = 0;
    while (d.size() < 88 && idx < cap.size()) begin
      bit b = cap[idx];
      idx++;
      if (ones == 5) begin ones = 0; continue; end
      d.push_back(b);
      ones = b ? ones + 1 : 0;
    end
    got = '0;
    if (d.size() == 88) for (int k = 0; k < 16; k++) got[k] = d[72 + k];
    check(got == 16'h906E, "R3", "destuffed FCS of check string", got, 16'h906E);
  endtask

  task automatic testAbort();
    int z, mm;
    goIdle();
    pushEntry(8'h11, 1'b0, 1'b0);
    pushEntry(8'h22, 1'b0, 1'b0);
    pushEntry(8'h00, 1'b0, 1'b1);
    frameBytes = '{8'h11, 8'h22};
    addFrame(1'b0);
    addRaw(8'hFF);
    waitBits(80);
    z = firstZero();
    mm = mismatchAt(z);
    check(mm == -1, "R5", "abort frame mismatch index", mm, -1);
    check(z >= 0 && eopCap[z + 31] == 1'b1 && countOnes(eopCap) == 1,
          "R10", "eop on last abort bit", countOnes(eopCap), 1);
    check(countOnes(ufCap) == 0, "R5", "no underrun on tagged abort", countOnes(ufCap), 0);
    check(pushReady == 1'b1 && txBit == 1'b1, "R5", "line back to fill", txBit, 1);
  endtask

  task automatic testUnderrun();
    int z, mm;
    goIdle();
    pushEntry(8'hA5, 1'b0, 1'b0);
    frameBytes = '{8'hA5};
    addFrame(1'b0);
    addRaw(8'hFF);
    waitBits(60);
    z = firstZero();
    mm = mismatchAt(z);
    check(mm == -1, "R6", "underrun frame mismatch index", mm, -1);
    check(z >= 0 && ufCap[z + 16] == 1'b1 && countOnes(ufCap) == 1,
          "R6", "underrun on first abort bit only", countOnes(ufCap), 1);
    check(z >= 0 && eopCap[z + 23] == 1'b1, "R10", "eop at underrun abort end", 0, 1);
  endtask

  task automatic testBackToBack();
    int z, mm;
    goIdle();
    frameBytes = '{8'h01, 8'h02};
    pushFrame();
    addFrame(1'b1);
    frameBytes = '{8'hF0, 8'h0F};
    pushFrame();
    addFrame(1'b1);
    waitBits(expQ.size() + 40);
    z = firstZero();
    mm = mismatchAt(z);
    check(mm == -1, "R12", "two frames contiguous mismatch index", mm, -1);
    check(countOnes(eopCap) == 2, "R10", "eop count for two frames", countOnes(eopCap), 2);
  endtask

  task automatic testFlagFill();
    setPat(9'h07E, 8);
    fillMode = 2'b01;
    waitBits(20);
    clearCap();
    waitBits(80);
    check(periodic(), "R8", "mode 01 flag fill", cap.size(), 80);
    fillMode = 2'b11;
    waitBits(20);
    clearCap();
    waitBits(80);
    check(periodic(), "R8", "mode 11 flag fill", cap.size(), 80);
  endtask

  task automatic testGoAhead();
    int s, after;
    setPat(9'h0FE, 9);
    fillMode = 2'b10;
    waitBits(30);
    clearCap();
    waitBits(90);
    check(periodic(), "R9", "go ahead pattern", cap.size(), 90);
    frameBytes = '{8'hC3, 8'h3C, 8'h81, 8'h18};
    pushFrame();
    @(negedge clk);
    check(pushReady == 1'b0, "R13", "pushReady when full", pushReady, 0);
    pushValid = 1'b1; pushData = 8'h99; pushLast = 1'b1;
    @(negedge clk);
    pushValid = 1'b0; pushLast = 1'b0;
    waitBits(60);
    check(periodic(), "R9", "go ahead held with data queued", cap.size(), 150);
    clearCap(); expQ.delete();
    fillMode = 2'b00;
    addFrame(1'b1);
    waitBits(expQ.size() + 60);
    s = findSeq();
    check(s >= 0, "R9", "queued frame after mode change", s, 0);
    after = 0;
    if (s >= 0) for (int i = s + expQ.size(); i < cap.size(); i++) after += (cap[i] == 1'b0);
    check(s >= 0 && after == 0, "R13", "dropped push never sent", after, 0);
    check(pushReady == 1'b1, "R13", "queue drained", pushReady, 1);
  endtask

  task automatic testGated();
    enPeriod = 3;
    waitBits(4);
    holdErr = 0;
    frameBytes = '{8'hA7, 8'h5C, 8'hFE};
    runIdleFrame("R11");
    check(holdErr == 0, "R11", "line changes without bitEn", holdErr, 0);
    enPeriod = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testPlainFrame();
    testStuffFrame();
    testCheckVector();
    testAbort();
    testUnderrun();
    testBackToBack();
    testFlagFill();
    testGoAhead();
    testGated();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule